// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small bank of binary ownership tokens that two independent agents, a left port and a right port, use to coordinate access to a shared resource. Each port reaches the bank by raising its semaphore select while its memory chip select is low. It names a token with the lowest address bits. A write uses data bit 0 only: a 0 asks for the token and a 1 withdraws the request. A read returns the token's status, active low and copied onto every data bit.

Each token keeps one request latch per side. A request from the side that does not own the token stays pending. When the owner withdraws, the token passes to the waiting side on the same clock edge. If both sides ask for a free token on the same edge, the left side wins. A read value is captured on the first cycle of a read access and stays fixed until the access ends.

All pins are plain control and status signals clocked on `clk` with a synchronous active-high `rst`. An access takes one cycle, so there is no valid/ready handshake and no back-pressure. A port may start a write or a read on any cycle.

Top module: `sem_bank`

## Requirements
- R1: After reset every token is free. A read from either side returns 16'hFFFF, and `*_rdata` is 16'hFFFF whenever no read access is in progress.
- R2: The token index is taken from `addr[2:0]` only. The upper address bits have no effect on which token a write or read reaches.
- R3: A write (`sem_sel`=1, `mem_cs`=0, `we`=1) loads `wdata[0]` into that side's request latch for the addressed token: 0 requests and 1 withdraws. Bits 15..1 are ignored. A withdrawal by a side that owns nothing leaves the other side's ownership unchanged.
- R4: A request on a free token makes the requesting side the owner at that clock edge. The owner reads 16'h0000 and the other side reads 16'hFFFF.
- R5: A request from the non-owner stays pending, and that side still reads 16'hFFFF. When the owner withdraws, the pending side becomes owner on the same edge.
- R6: When both sides request a free token on the same edge, the left side becomes owner and the right request stays pending. The two sides never both read 16'h0000.
- R7: A read (`sem_sel`=1, `mem_cs`=0, `oe`=1, `we`=0) captures the token value at its first edge. From the next cycle `*_rdata` shows that bit on all 16 lines. The value holds until `sem_sel` or `oe` drops, even if ownership changes meanwhile.
- R8: A pending or owning request stays in force until its own side writes 1. Writes from the other side do not clear it.
- R9: Any access made while `mem_cs`=1 is ignored. It changes no latch and leaves `*_rdata` at 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_sem_sel | input | 1 | Left semaphore select |
| l_mem_cs | input | 1 | Left memory chip select; blocks semaphore access when 1 |
| l_we | input | 1 | Left write strobe |
| l_oe | input | 1 | Left output enable |
| l_addr | input | 15 | Left address; bits 2..0 pick the token |
| l_wdata | input | 16 | Left write data; bit 0 used |
| l_rdata | output | 16 | Left read data |
| r_sem_sel | input | 1 | Right semaphore select |
| r_mem_cs | input | 1 | Right memory chip select; blocks semaphore access when 1 |
| r_we | input | 1 | Right write strobe |
| r_oe | input | 1 | Right output enable |
| r_addr | input | 15 | Right address; bits 2..0 pick the token |
| r_wdata | input | 16 | Right write data; bit 0 used |
| r_rdata | output | 16 | Right read data |

## Verification
A corrupted request latch stays invisible while the other side owns the token. It shows up only at the handoff: on the first read after the owner withdraws, the waiting side reads 16'hFFFF instead of 16'h0000, or the reverse. For that reason the bench drives explicit pend-then-release sequences. A wrong owner state appears on the next read as both sides reading 0 or both reading 1 for a held token. A broken read hold shows up one cycle after an ownership change made during an open read.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_t;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 16,
  localparam int FLAG_AW  = $clog2(NUM_FLAGS)
) (
  input  logic                 sem_sel,
  input  logic                 mem_cs,
  input  logic                 we,
  input  logic                 oe,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [NUM_FLAGS-1:0] wr_stb,
  output logic                 wr_bit,
  output logic                 rd_act,
  output logic [FLAG_AW-1:0]   rd_idx
);
  logic access;
  logic unused_bits;

  // semaphore space is reachable only while the memory select is idle
  assign access = sem_sel & ~mem_cs;
  assign rd_act = access & oe & ~we;
  assign rd_idx = addr[FLAG_AW-1:0];
  assign wr_bit = wdata[0];
  assign unused_bits = ^{addr[ADDR_W-1:FLAG_AW], wdata[DATA_W-1:1]};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_stb
    assign wr_stb[i] = access & we & (addr[FLAG_AW-1:0] == FLAG_AW'(i));
  end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic l_wr,
  input  logic l_bit,
  input  logic r_wr,
  input  logic r_bit,
  output logic l_view,
  output logic r_view
);
  logic   req_l, req_r;   // 0 = request in force
  logic   nxt_l, nxt_r;
  owner_t owner, owner_nxt;

  always_comb begin
    nxt_l = l_wr ? l_bit : req_l;
    nxt_r = r_wr ? r_bit : req_r;
    owner_nxt = owner;
    unique case (owner)
      OWN_LEFT:  if (nxt_l)  owner_nxt = nxt_r ? OWN_NONE : OWN_RIGHT;
      OWN_RIGHT: if (nxt_r)  owner_nxt = nxt_l ? OWN_NONE : OWN_LEFT;
      default: begin
        if (!nxt_l)      owner_nxt = OWN_LEFT;
        else if (!nxt_r) owner_nxt = OWN_RIGHT;
        else             owner_nxt = OWN_NONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_l <= 1'b1;
      req_r <= 1'b1;
      owner <= OWN_NONE;
    end else begin
      req_l <= nxt_l;
      req_r <= nxt_r;
      owner <= owner_nxt;
    end
  end

  assign l_view = (owner != OWN_LEFT);
  assign r_view = (owner != OWN_RIGHT);

  // R8: an owner keeps the token until its own side writes 1
  p_keep_token_r8: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_LEFT && !(l_wr && l_bit)) |=> (owner == OWN_LEFT));
  // R5: release with a pending opposite request hands over at once
  p_handoff_r5: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_LEFT && l_wr && l_bit && !req_r && !r_wr) |=> (owner == OWN_RIGHT));
  // R6: same-edge requests on a free token go to the left side
  p_tie_left_r6: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_NONE && l_wr && !l_bit && r_wr && !r_bit) |=> (owner == OWN_LEFT && !req_r));
endmodule

// File: rtl/sem_read_hold.sv
module sem_read_hold #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 16,
  localparam int FLAG_AW  = $clog2(NUM_FLAGS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_act,
  input  logic [FLAG_AW-1:0]   rd_idx,
  input  logic [NUM_FLAGS-1:0] view,
  output logic [DATA_W-1:0]    rdata
);
  logic held, on;

  always_ff @(posedge clk) begin
    if (rst) begin
      on   <= 1'b0;
      held <= 1'b1;
    end else begin
      on <= rd_act;
      if (rd_act && !on) held <= view[rd_idx];
    end
  end

  assign rdata = on ? {DATA_W{held}} : {DATA_W{1'b1}};

  // R7: a continuing read keeps its captured value
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_act && on) |=> $stable(rdata));
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 16,
  localparam int FLAG_AW  = $clog2(NUM_FLAGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sem_sel,
  input  logic              l_mem_cs,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sem_sel,
  input  logic              r_mem_cs,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  logic [NUM_FLAGS-1:0] l_stb, r_stb, l_view, r_view;
  logic                 l_bit, r_bit, l_rd, r_rd;
  logic [FLAG_AW-1:0]   l_idx, r_idx;

  sem_port_dec #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
    .sem_sel(l_sem_sel), .mem_cs(l_mem_cs), .we(l_we), .oe(l_oe),
    .addr(l_addr), .wdata(l_wdata),
    .wr_stb(l_stb), .wr_bit(l_bit), .rd_act(l_rd), .rd_idx(l_idx));

  sem_port_dec #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
    .sem_sel(r_sem_sel), .mem_cs(r_mem_cs), .we(r_we), .oe(r_oe),
    .addr(r_addr), .wdata(r_wdata),
    .wr_stb(r_stb), .wr_bit(r_bit), .rd_act(r_rd), .rd_idx(r_idx));

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    sem_flag_cell u_cell (
      .clk(clk), .rst(rst),
      .l_wr(l_stb[i]), .l_bit(l_bit),
      .r_wr(r_stb[i]), .r_bit(r_bit),
      .l_view(l_view[i]), .r_view(r_view[i]));
  end

  sem_read_hold #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_hold_l (
    .clk(clk), .rst(rst), .rd_act(l_rd), .rd_idx(l_idx), .view(l_view), .rdata(l_rdata));

  sem_read_hold #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_hold_r (
    .clk(clk), .rst(rst), .rd_act(r_rd), .rd_idx(r_idx), .view(r_view), .rdata(r_rdata));

  // R9: an access with the memory select high leaves the read port idle
  p_ignored_l_r9: assert property (@(posedge clk) disable iff (rst)
    l_mem_cs |=> (l_rdata == {DATA_W{1'b1}}));
  p_ignored_r_r9: assert property (@(posedge clk) disable iff (rst)
    r_mem_cs |=> (r_rdata == {DATA_W{1'b1}}));
  // R6: the two sides never both hold a token
  p_one_owner_r6: assert property (@(posedge clk) disable iff (rst)
    ((~l_view) & (~r_view)) == '0);
endmodule

// File: tb/sim_sem_bank.sv
module sim_sem_bank;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] ONES = 16'hFFFF;

  logic clk = 1'b0;
  logic rst;
  logic l_sem_sel, l_mem_cs, l_we, l_oe, r_sem_sel, r_mem_cs, r_we, r_oe;
  logic [14:0] l_addr, r_addr;
  logic [15:0] l_wdata, r_wdata, l_rdata, r_rdata;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sem_bank u0 (.*);

  // vector: lw la[3] ld rw ra[3] rd chk_flag[3] exp_l exp_r pad
  function automatic logic [15:0] v(input logic lw, input logic [2:0] la, input logic ld,
                                    input logic rw, input logic [2:0] ra, input logic rd,
                                    input logic [2:0] cf, input logic el, input logic er);
    return {lw, la, ld, rw, ra, rd, cf, el, er, 1'b0};
  endfunction

  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    v(1,2,0, 0,0,1, 2,0,1),  // R4 left takes free token 2
    v(0,0,1, 1,2,0, 2,0,1),  // R5 right pends on 2
    v(1,2,1, 0,0,1, 2,1,0),  // R5 left releases, right gets it
    v(1,2,0, 0,0,1, 2,1,0),  // R5 left pends
    v(0,0,1, 1,2,1, 2,0,1),  // R5 right releases, left gets it
    v(1,2,1, 0,0,1, 2,1,1),  // R4 token 2 free again
    v(1,5,0, 1,5,0, 5,0,1),  // R6 tie goes left
    v(0,0,1, 1,5,1, 5,0,1),  // R8 right withdraws its pending request
    v(1,5,1, 0,0,1, 5,1,1),  // R8 no handoff after withdrawal
    v(1,7,1, 1,7,0, 7,1,0),  // R3 left 1 on free token has no effect
    v(1,0,0, 1,1,0, 0,0,1),  // R2 separate tokens
    v(0,0,1, 0,0,1, 1,1,0)   // R2 token 1 held by right
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    l_sem_sel = 0; l_mem_cs = 0; l_we = 0; l_oe = 0; l_addr = '0; l_wdata = '1;
    r_sem_sel = 0; r_mem_cs = 0; r_we = 0; r_oe = 0; r_addr = '0; r_wdata = '1;
  endtask

  task automatic wr2(input logic lw, input logic [14:0] la, input logic [15:0] ld,
                     input logic rw, input logic [14:0] ra, input logic [15:0] rd);
    @(negedge clk);
    l_sem_sel = lw; l_we = lw; l_addr = la; l_wdata = ld;
    r_sem_sel = rw; r_we = rw; r_addr = ra; r_wdata = rd;
    @(negedge clk);
    idle();
  endtask

  task automatic rd2(input logic [14:0] la, input logic [14:0] ra,
                     input logic [15:0] el, input logic [15:0] er, input string tag);
    @(negedge clk);
    l_sem_sel = 1; l_oe = 1; l_addr = la;
    r_sem_sel = 1; r_oe = 1; r_addr = ra;
    @(negedge clk);
    chk({tag, " left"}, l_rdata, el);
    chk({tag, " right"}, r_rdata, er);
    idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 idle left", l_rdata, ONES);
    chk("R1 idle right", r_rdata, ONES);
    rd2(15'd0, 15'd0, ONES, ONES, "R1 token0 free");
    rd2(15'd6, 15'd6, ONES, ONES, "R1 token6 free");

    // table walk (R3, R4, R5, R6, R8, R2)
    for (int i = 0; i < NV; i++) begin
      logic [15:0] e;
      e = VEC[i];
      wr2(e[15], {12'd0, e[14:12]}, {15'd0, e[11]}, e[10], {12'd0, e[9:7]}, {15'd0, e[6]});
      rd2({12'd0, e[5:3]}, {12'd0, e[5:3]}, {16{e[2]}}, {16{e[1]}},
          $sformatf("table R4/R5/R6/R8/R3 step %0d", i));
    end

    // R2: upper address bits ignored; R3: only bit 0 of data used
    wr2(1, 15'h7FF3, 16'hFFFE, 0, 15'd0, ONES);
    rd2(15'h0003, 15'h5553, 16'h0000, ONES, "R2 R3 request via aliased address");

    // R9: read with memory select high returns idle ones
    @(negedge clk);
    l_sem_sel = 1; l_oe = 1; l_mem_cs = 1; l_addr = 15'd3;
    @(negedge clk);
    chk("R9 read blocked", l_rdata, ONES);
    idle();
    // R9: write with memory select high changes nothing
    @(negedge clk);
    r_sem_sel = 1; r_we = 1; r_mem_cs = 1; r_addr = 15'd4; r_wdata = 16'h0000;
    @(negedge clk);
    idle();
    rd2(15'd4, 15'd4, ONES, ONES, "R9 write blocked");

    // R3: release with bit0=1, other bits 0
    wr2(1, 15'd3, 16'h0001, 0, 15'd0, ONES);
    rd2(15'd3, 15'd3, ONES, ONES, "R3 release");

    // R7: held read across an ownership change
    wr2(0, 15'd0, ONES, 1, 15'd6, 16'h0000);
    wr2(1, 15'd6, 16'h0000, 0, 15'd0, ONES);
    @(negedge clk);
    l_sem_sel = 1; l_oe = 1; l_addr = 15'd6;
    @(negedge clk);
    chk("R7 captured", l_rdata, ONES);
    r_sem_sel = 1; r_we = 1; r_addr = 15'd6; r_wdata = ONES;
    @(negedge clk);
    r_sem_sel = 0; r_we = 0;
    chk("R7 held after handoff", l_rdata, ONES);
    @(negedge clk);
    chk("R7 still held", l_rdata, ONES);
    idle();
    @(negedge clk);
    rd2(15'd6, 15'd6, 16'h0000, ONES, "R5 R7 fresh read after handoff");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule